// File: doc/BRIEF.md
# Strobed Serial PCM Timeslot Port

This block carries one 8-bit PCM sample each way per frame across a synchronous serial link. The link has a bit clock, an active-high strobe that marks the one 8-bit timeslot used for both directions, a serial data input and a serial data output with its own drive enable. On the parallel side it takes one sign-magnitude byte from the codec core per frame. It returns the received byte in sign-magnitude form together with a one-cycle valid pulse.

All link inputs are brought into the fast system clock domain and oversampled there, so the bit-clock edges become single-cycle events. When the strobe falls, the block raises a cascade strobe that lasts eight bit clocks. A second port can use it as its own timeslot strobe in the following slot. Bytes are recoded between sign-magnitude and the chosen line code as they pass. The choices are µ-law (magnitude bits inverted), A-law (even bits inverted), or plain sign-magnitude.

Top module: `pcm_slot_port`

## Requirements
- R1: The drive enable `sdata_oe_o` is high only while the block is inside its timeslot: from the first bit-clock rising edge that sees the strobe high until the rising edge after the eighth bit. It is low at all other times.
- R2: Transmit bits go out MSB first (bit 7 is the sign), and each new bit is driven after a bit-clock rising edge. The transmit byte and the coding choice are captured at the slot's first rising edge, so later changes to them during the slot have no effect.
- R3: Receive bits are sampled on bit-clock falling edges, MSB first, inside the slot. After the eighth sample, `rx_valid_o` pulses high for exactly one system clock with the decoded byte on `rx_byte_o`.
- R4: With µ-law selected, the line code is the sign bit followed by the inverted 7 magnitude bits. For example, sign-magnitude 0xFF maps to 0x80, and 0x7F maps to 0x00.
- R5: With A-law selected, the line code is the sign-magnitude byte XOR 0x55. For example, 0xFF maps to 0xAA, and 0x00 maps to 0x55.
- R6: With `smag_sel_i` = 1, bytes pass unchanged in both directions, whatever law is selected.
- R7: The active law is A-law when `law_pin_i` OR `law_reg_i` is 1, and µ-law when both are 0.
- R8: If the strobe stays high for more than eight bit clocks, only the first eight bits are sent and received. The drive enable stays low for the rest of the strobe, and only one valid pulse is given.
- R9: After the strobe is seen low at a rising edge that follows a slot, `cas_strobe_o` goes high for exactly eight bit clocks. It is never high while the block drives its own slot.
- R10: While `rst_ni` is low, `sdata_oe_o`, `cas_strobe_o` and `rx_valid_o` are low. The stored coding choice returns to µ-law with G.711 coding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the link |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| strobe_i | input | 1 | Active-high timeslot strobe |
| sdata_i | input | 1 | Serial receive data |
| sdata_o | output | 1 | Serial transmit data |
| sdata_oe_o | output | 1 | Drive enable for the three-state data output |
| cas_strobe_o | output | 1 | Delayed strobe for a cascaded device |
| law_pin_i | input | 1 | Law select from the pin, 1 = A-law |
| law_reg_i | input | 1 | Law select from a register bit, 1 = A-law |
| smag_sel_i | input | 1 | 1 = sign-magnitude on the line, 0 = G.711 |
| tx_byte_i | input | 8 | Sign-magnitude byte to transmit |
| rx_byte_o | output | 8 | Received byte in sign-magnitude form |
| rx_valid_o | output | 1 | One-cycle pulse when rx_byte_o is new |

## Verification
The recoding paths are driven with full-scale, zero and mixed-bit bytes under each law and coding choice. These show apart sign handling from magnitude inversion and alternate-bit inversion. Law select is set once from the pin and once from the register bit to prove the OR. An overlong strobe, a mid-slot change of the transmit byte and law, and a reset in mid-slot are used to tell a block that honours slot capture and the eight-bit limit from one that follows its inputs live. The cascade strobe is counted in bit clocks both during and after each slot.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int PCM_W = 8;

  typedef enum logic {LAW_MU = 1'b0, LAW_A = 1'b1} law_e;

  typedef struct packed {
    law_e law;
    logic smag;
  } code_cfg_t;

  localparam code_cfg_t CFG_RESET = '{law: LAW_MU, smag: 1'b0};

  // Both mappings are involutions: one function serves encode and decode.
  function automatic logic [PCM_W-1:0] recode(input logic [PCM_W-1:0] b,
                                              input code_cfg_t c);
    logic [PCM_W-1:0] adi;
    for (int i = 0; i < PCM_W; i++) adi[i] = ~i[0];
    if (c.smag) return b;
    if (c.law == LAW_A) return b ^ adi;
    return {b[PCM_W-1], ~b[PCM_W-2:0]};
  endfunction
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int N       = 3,
  parameter int STAGES  = 2,
  parameter int CLK_IDX = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o,
  output logic         clk_rise_o,
  output logic         clk_fall_o
);
  logic [N-1:0] stg_q [STAGES];
  logic         prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= async_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= stg_q[STAGES-1][CLK_IDX];

  assign sync_o     = stg_q[STAGES-1];
  assign clk_rise_o = sync_o[CLK_IDX] & ~prev_q;
  assign clk_fall_o = ~sync_o[CLK_IDX] & prev_q;
endmodule

// File: rtl/pcm_recode.sv
module pcm_recode
  import pcm_port_pkg::*;
(
  input  logic [PCM_W-1:0] din_i,
  input  code_cfg_t        cfg_i,
  output logic [PCM_W-1:0] dout_o
);
  assign dout_o = recode(din_i, cfg_i);
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bclk_rise_i,
  input  logic         strobe_i,
  input  logic [W-1:0] load_i,
  output logic         slot_start_o,
  output logic         cas_trig_o,
  output logic         sdata_o,
  output logic         oe_o
);
  localparam int IW = $clog2(W);

  logic         in_slot_q, done_q;
  logic [IW-1:0] idx_q;
  logic [W-1:0] sh_q;

  assign slot_start_o = bclk_rise_i & strobe_i & ~in_slot_q & ~done_q;
  assign cas_trig_o   = bclk_rise_i & ~strobe_i & (in_slot_q | done_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_slot_q <= 1'b0;
      done_q    <= 1'b0;
      idx_q     <= '0;
      sh_q      <= '0;
    end else if (bclk_rise_i) begin
      if (!strobe_i) begin
        in_slot_q <= 1'b0;
        done_q    <= 1'b0;
      end else if (slot_start_o) begin
        sh_q      <= load_i;
        in_slot_q <= 1'b1;
        idx_q     <= '0;
      end else if (in_slot_q) begin
        if (idx_q == IW'(W-1)) begin
          in_slot_q <= 1'b0;  // overlong strobe: stop after W bits
          done_q    <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {sh_q[W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdata_o = sh_q[W-1];
  assign oe_o    = in_slot_q;

  p_oe_needs_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> strobe_i);
  p_bit_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !bclk_rise_i) |=> $stable(sdata_o));
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bclk_fall_i,
  input  logic         sdata_i,
  input  logic         clear_i,
  input  logic         active_i,
  output logic [W-1:0] line_o,
  output logic         valid_o
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q, line_q;
  logic          valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      line_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (clear_i) begin
        cnt_q <= '0;
      end else if (bclk_fall_i && active_i && cnt_q < CW'(W)) begin
        sh_q  <= {sh_q[W-2:0], sdata_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(W-1)) begin
          line_q  <= {sh_q[W-2:0], sdata_i};
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign line_o  = line_q;
  assign valid_o = valid_q;

  p_valid_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  p_bit_limit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(W));
endmodule

// File: rtl/pcm_cas_strobe.sv
module pcm_cas_strobe #(
  parameter int LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_rise_i,
  input  logic trig_i,
  output logic cas_o
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic          cas_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cas_q <= 1'b0;
      cnt_q <= '0;
    end else if (trig_i) begin
      cas_q <= 1'b1;
      cnt_q <= '0;
    end else if (bclk_rise_i && cas_q) begin
      if (cnt_q == CW'(LEN-1)) cas_q <= 1'b0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cas_o = cas_q;

  p_cas_starts_on_trig_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_q) |-> $past(trig_i));
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CAS_BITS    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_i,
  input  logic             strobe_i,
  input  logic             sdata_i,
  output logic             sdata_o,
  output logic             sdata_oe_o,
  output logic             cas_strobe_o,
  input  logic             law_pin_i,
  input  logic             law_reg_i,
  input  logic             smag_sel_i,
  input  logic [PCM_W-1:0] tx_byte_i,
  output logic [PCM_W-1:0] rx_byte_o,
  output logic             rx_valid_o
);
  logic [2:0]       sync;
  logic             bclk_rise, bclk_fall;
  logic             slot_start, cas_trig;
  logic [PCM_W-1:0] tx_line, rx_line;
  code_cfg_t        cfg_live, cfg_q;

  pcm_edge_sync #(.N(3), .STAGES(SYNC_STAGES), .CLK_IDX(0)) u_sync (
    .clk_i, .rst_ni,
    .async_i    ({sdata_i, strobe_i, bclk_i}),
    .sync_o     (sync),
    .clk_rise_o (bclk_rise),
    .clk_fall_o (bclk_fall)
  );

  assign cfg_live = '{law: law_e'(law_pin_i | law_reg_i), smag: smag_sel_i};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         cfg_q <= CFG_RESET;
    else if (slot_start) cfg_q <= cfg_live;

  pcm_recode u_enc (.din_i(tx_byte_i), .cfg_i(cfg_live), .dout_o(tx_line));

  pcm_tx_slot #(.W(PCM_W)) u_tx (
    .clk_i, .rst_ni,
    .bclk_rise_i  (bclk_rise),
    .strobe_i     (sync[1]),
    .load_i       (tx_line),
    .slot_start_o (slot_start),
    .cas_trig_o   (cas_trig),
    .sdata_o      (sdata_o),
    .oe_o         (sdata_oe_o)
  );

  pcm_rx_slot #(.W(PCM_W)) u_rx (
    .clk_i, .rst_ni,
    .bclk_fall_i (bclk_fall),
    .sdata_i     (sync[2]),
    .clear_i     (slot_start),
    .active_i    (sdata_oe_o),
    .line_o      (rx_line),
    .valid_o     (rx_valid_o)
  );

  pcm_recode u_dec (.din_i(rx_line), .cfg_i(cfg_q), .dout_o(rx_byte_o));

  pcm_cas_strobe #(.LEN(CAS_BITS)) u_cas (
    .clk_i, .rst_ni,
    .bclk_rise_i (bclk_rise),
    .trig_i      (cas_trig),
    .cas_o       (cas_strobe_o)
  );

  p_cas_no_overlap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_strobe_o |-> !sdata_oe_o);
  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_start |=> $stable(cfg_q));
endmodule

// File: tb/pcm_slot_port_bench.sv
module pcm_slot_port_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bclk_i = 1'b0;
  logic strobe_i = 1'b0, sdata_i = 1'b0;
  logic law_pin_i = 1'b0, law_reg_i = 1'b0, smag_sel_i = 1'b0;
  logic [7:0] tx_byte_i = 8'h00;
  logic sdata_o, sdata_oe_o, cas_strobe_o, rx_valid_o;
  logic [7:0] rx_byte_o;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  int bdiv = 0;
  always @(negedge clk_i) begin
    bdiv <= (bdiv == 7) ? 0 : bdiv + 1;
    if (bdiv == 7) bclk_i <= ~bclk_i;
  end

  pcm_slot_port u_pcm_slot_port (.*);

  int vcount = 0;
  logic [7:0] vbyte = 8'h00;
  always @(negedge clk_i)
    if (rst_ni && rx_valid_o) begin
      vcount++;
      vbyte = rx_byte_o;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {pin, reg, smag, pad, tx_smag, rx_line, exp_tx_line, exp_rx_smag}
  localparam logic [35:0] VEC [8] = '{
    {4'b0000, 8'hFF, 8'hFF, 8'h80, 8'h80},
    {4'b1000, 8'hFF, 8'h55, 8'hAA, 8'h00},
    {4'b0100, 8'h00, 8'h2A, 8'h55, 8'h7F},
    {4'b0000, 8'h7F, 8'h7F, 8'h00, 8'h00},
    {4'b0010, 8'h3C, 8'hA5, 8'h3C, 8'hA5},
    {4'b1100, 8'h3C, 8'h96, 8'h69, 8'hC3},
    {4'b0000, 8'h96, 8'h5A, 8'hE9, 8'h25},
    {4'b1010, 8'h80, 8'h01, 8'h80, 8'h01}
  };

  logic [7:0] got_line;
  int oe_cnt, oe_extra, cas_in_slot, cas_after;

  task automatic run_frame(input logic [7:0] line_in, input int nbits, input bit mid_change);
    got_line = 8'h00; oe_cnt = 0; oe_extra = 0; cas_in_slot = 0; cas_after = 0;
    vcount = 0;
    @(negedge bclk_i);
    strobe_i = 1'b1;
    for (int k = 1; k <= nbits; k++) begin
      @(posedge bclk_i);
      sdata_i = (k <= 8) ? line_in[8-k] : 1'b0;
      if (mid_change && k == 3) begin
        tx_byte_i = 8'h00;
        law_reg_i = 1'b1;
      end
      @(negedge bclk_i);
      if (k <= 8) begin
        got_line[8-k] = sdata_o;
        if (sdata_oe_o) oe_cnt++;
      end else if (sdata_oe_o) oe_extra++;
      if (cas_strobe_o) cas_in_slot++;
      if (k == nbits) strobe_i = 1'b0;
    end
    for (int k = 0; k < 12; k++) begin
      @(negedge bclk_i);
      if (cas_strobe_o) cas_after++;
      if (sdata_oe_o) oe_extra++;
    end
  endtask

  initial begin
    repeat (40) @(negedge clk_i);
    chk("R10 oe in reset", sdata_oe_o, 0);
    chk("R10 cas in reset", cas_strobe_o, 0);
    chk("R10 valid in reset", rx_valid_o, 0);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    chk("R1 oe idle", sdata_oe_o, 0);

    for (int v = 0; v < 8; v++) begin
      {law_pin_i, law_reg_i, smag_sel_i} = VEC[v][35:33];
      tx_byte_i = VEC[v][31:24];
      run_frame(VEC[v][23:16], 8, 1'b0);
      chk($sformatf("R2 R4 R5 R6 R7 tx line vec%0d", v), got_line, VEC[v][15:8]);
      chk($sformatf("R3 R4 R5 R6 R7 rx byte vec%0d", v), vbyte, VEC[v][7:0]);
      chk($sformatf("R3 valid count vec%0d", v), vcount, 1);
      chk($sformatf("R1 oe bits vec%0d", v), oe_cnt, 8);
      chk($sformatf("R1 oe outside vec%0d", v), oe_extra, 0);
      chk($sformatf("R9 cas in slot vec%0d", v), cas_in_slot, 0);
      chk($sformatf("R9 cas width vec%0d", v), cas_after, 8);
    end

    // R8: overlong strobe of 12 bits
    {law_pin_i, law_reg_i, smag_sel_i} = 3'b000;
    tx_byte_i = 8'h96;
    run_frame(8'h5A, 12, 1'b0);
    chk("R8 tx line long strobe", got_line, 8'hE9);
    chk("R8 rx byte long strobe", vbyte, 8'h25);
    chk("R8 single valid", vcount, 1);
    chk("R8 oe after bit 8", oe_extra, 0);
    chk("R8 R9 cas width long strobe", cas_after, 8);

    // R2: byte and law changed mid-slot have no effect
    {law_pin_i, law_reg_i, smag_sel_i} = 3'b000;
    tx_byte_i = 8'h96;
    run_frame(8'h5A, 8, 1'b1);
    chk("R2 mid-slot tx ignored", got_line, 8'hE9);
    chk("R2 mid-slot law ignored rx", vbyte, 8'h25);
    law_reg_i = 1'b0;

    // R10: reset in mid-slot
    @(negedge bclk_i);
    strobe_i = 1'b1;
    repeat (3) @(negedge bclk_i);
    chk("R1 oe inside slot", sdata_oe_o, 1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R10 oe cleared", sdata_oe_o, 0);
    chk("R10 cas cleared", cas_strobe_o, 0);
    strobe_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge bclk_i);
    chk("R10 cas after reset", cas_strobe_o, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule